// File: doc/BRIEF.md
# Contrast PWM Generator

This block drives one pulse-width-modulated pin whose average level, after an off-chip low-pass filter, sets a display contrast voltage. An 8-bit period counter advances on a divided clock tick. Within each period the pin sits at a selectable active level while the count is below a duty threshold, and at the opposite level for the rest of the period.

Three settings arrive as plain input ports: the duty threshold, the active level, and a 2-bit rate select that sets the tick divider. They are captured into held copies at the first enabled clock and again at every counter wrap. A setting changed mid-period therefore only shapes the next whole period. Dropping the enable parks the counter at zero and drives the pin to the idle level.

Top module: `contrast_pwm`

## Requirements
- R1: The period counter is CNT_W (8) bits wide. It advances by one on each tick and rolls over from 255 to 0, so one period spans 256 ticks.
- R2: Within a period, for each count value below the held duty threshold the pin equals the held active level, and it equals the inverse otherwise. The active-level part therefore sits at the start of the period.
- R3: A duty threshold of 0 never produces the active level: the pin is low for the whole period with active level 1, and high for the whole period with active level 0.
- R4: A duty threshold of 255 gives 255 high counts out of 256 with active level 1, and 1 high count out of 256 with active level 0.
- R5: Rate select values 0, 1, 2 and 3 make each count last 1, 2, 4 and 8 clocks respectively.
- R6: Duty, active level and rate select are captured only at the clock edge where the counter rolls over, or while the block is idle. A change during a period leaves that period untouched and shapes the following one.
- R7: One clock after enable is sampled low, the counter is 0 and the pin equals the inverse of the active-level input, following that input while idle. The first clock edge that samples enable high starts a period at count 0, using the inputs present at that edge.
- R8: While reset (active low, asynchronous) is asserted, the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable; low parks the counter and idles the pin |
| duty_i | input | 8 | Duty threshold, counts of active level per period |
| polarity_i | input | 1 | Active level driven while the count is below the threshold |
| rate_sel_i | input | 2 | Tick divider select: divide by 1, 2, 4 or 8 |
| pwm_o | output | 1 | Registered PWM pin |

## Verification
The bench uses the default parameters: an 8-bit counter and a 2-bit rate select. The slowest period is therefore 2048 clocks. Every clock of whole periods can be compared against the expected level, at all four rates and at both duty extremes for each active level. This size also leaves room to change settings mid-period and to see the change land exactly at the rollover, and to drop and restore enable in the middle of a period.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int unsigned DEF_CNT_W = 8;
    localparam int unsigned DEF_SEL_W = 2;

    // last divider value for a rate select: (2**sel) - 1
    function automatic logic [15:0] div_last(input logic [3:0] sel);
        return (16'd1 << sel) - 16'd1;
    endfunction

endpackage

// File: rtl/cpwm_rate_div.sv
module cpwm_rate_div #(
    parameter int unsigned SEL_W = cpwm_pkg::DEF_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [SEL_W-1:0] rate_sel_i,
    output logic             tick_o
);
    localparam int unsigned DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim    = DIV_W'(cpwm_pkg::div_last(4'(rate_sel_i)));
        tick_o = run_i && (div_q == lim);
        if (!run_i || tick_o) begin
            div_d = '0;
        end else begin
            div_d = div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (!tick_o || lim == '0)); // R5

    AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_q <= lim); // R5

endmodule

// File: rtl/cpwm_period_cnt.sv
module cpwm_period_cnt #(
    parameter int unsigned CNT_W = cpwm_pkg::DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap_o = run_i && tick_i && (cnt_q == CNT_MAX);
        if (!run_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_q_o = cnt_q;
    assign cnt_d_o = cnt_d;

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && tick_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R1

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !tick_i) |=> $stable(cnt_q)); // R1

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> cnt_q == '0); // R7

endmodule

// File: rtl/cpwm_cfg_hold.sv
module cpwm_cfg_hold #(
    parameter int unsigned CNT_W = cpwm_pkg::DEF_CNT_W,
    parameter int unsigned SEL_W = cpwm_pkg::DEF_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             pol_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] duty_q_o,
    output logic             pol_q_o,
    output logic [SEL_W-1:0] sel_q_o,
    output logic [CNT_W-1:0] duty_d_o,
    output logic             pol_d_o
);
    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic             pol;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.duty = duty_i;
            cfg_d.pol  = pol_i;
            cfg_d.sel  = sel_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{duty: '0, pol: 1'b1, sel: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign duty_q_o = cfg_q.duty;
    assign pol_q_o  = cfg_q.pol;
    assign sel_q_o  = cfg_q.sel;
    assign duty_d_o = cfg_d.duty;
    assign pol_d_o  = cfg_d.pol;

endmodule

// File: rtl/contrast_pwm.sv
module contrast_pwm #(
    parameter int unsigned CNT_W = cpwm_pkg::DEF_CNT_W,
    parameter int unsigned SEL_W = cpwm_pkg::DEF_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             polarity_i,
    input  logic [SEL_W-1:0] rate_sel_i,
    output logic             pwm_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic en;
        logic pwm;
    } top_state_t;

    top_state_t st_d, st_q;

    logic             run;
    logic             tick;
    logic             wrap;
    logic             load;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] duty_q, duty_d;
    logic             pol_q, pol_d;
    logic [SEL_W-1:0] sel_q;

    // the counter only runs once enable has been seen on two edges in a row,
    // so the first enabled edge parks it at zero and opens a period
    assign run  = enable_i && st_q.en;
    assign load = !enable_i || !st_q.en || wrap;

    cpwm_rate_div #(.SEL_W(SEL_W)) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run),
        .rate_sel_i (sel_q),
        .tick_o     (tick)
    );

    cpwm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .tick_i  (tick),
        .cnt_q_o (cnt_q),
        .cnt_d_o (cnt_d),
        .wrap_o  (wrap)
    );

    cpwm_cfg_hold #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load),
        .duty_i   (duty_i),
        .pol_i    (polarity_i),
        .sel_i    (rate_sel_i),
        .duty_q_o (duty_q),
        .pol_q_o  (pol_q),
        .sel_q_o  (sel_q),
        .duty_d_o (duty_d),
        .pol_d_o  (pol_d)
    );

    // output level is formed from next-state values so the registered pin
    // lines up with the registered count
    always_comb begin
        st_d.en = enable_i;
        if (enable_i && (cnt_d < duty_d)) begin
            st_d.pwm = pol_d;
        end else begin
            st_d.pwm = !pol_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{en: 1'b0, pwm: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.pwm;

    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> pwm_o == !$past(polarity_i)); // R7

    AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en && duty_q == '0) |-> pwm_o == !pol_q); // R3

    AST_START_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en && cnt_q == '0 && duty_q != '0) |-> pwm_o == pol_q); // R2

    AST_LAST_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en && cnt_q == CNT_MAX) |-> pwm_o == !pol_q); // R4

    AST_CFG_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en && enable_i && !wrap) |=> ($stable(duty_q) && $stable(pol_q) && $stable(sel_q))); // R6

endmodule

// File: tb/contrast_pwm_bench.sv
`timescale 1ns/1ps
module contrast_pwm_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] duty = '0;
    logic       pol = 1'b1;
    logic [1:0] sel = '0;
    logic       pwm;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    contrast_pwm u_contrast_pwm (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .enable_i   (enable),
        .duty_i     (duty),
        .polarity_i (pol),
        .rate_sel_i (sel),
        .pwm_o      (pwm)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // idle the block, set the inputs, then enable so the next edge opens a period
    task automatic start_run(input int c, input bit p, input int s);
        @(negedge clk);
        enable = 1'b0;
        duty   = 8'(c);
        pol    = p;
        sel    = 2'(s);
        @(negedge clk);
        @(negedge clk);
        check(pwm == !p, "R7", "idle level before enable", int'(pwm), int'(!p));
        enable = 1'b1;
    endtask

    // compare every clock of one period; optionally change inputs at sample chg_at
    task automatic measure(input int c, input bit p, input int s, input string req,
                           input int chg_at, input int nc, input bit np, input int ns);
        int d;
        int bad;
        int first;
        bit exp;
        d = 1 << s;
        bad = 0;
        first = -1;
        for (int i = 0; i < 256 * d; i++) begin
            @(negedge clk);
            exp = ((i / d) < c) ? p : !p;
            if (pwm !== exp) begin
                bad++;
                if (first < 0) first = i;
            end
            if (i == chg_at) begin
                duty = 8'(nc);
                pol  = np;
                sel  = 2'(ns);
            end
        end
        check(bad == 0, req, $sformatf("period duty=%0d pol=%0d sel=%0d mismatches (first at %0d)",
              c, p, s, first), bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(pwm == 1'b0, "R8", "pin during reset", int'(pwm), 0);
        rst_n = 1'b1;
        pol = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(pwm == 1'b1, "R7", "idle pin after reset, active level 0", int'(pwm), 1);
        pol = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(pwm == 1'b0, "R7", "idle pin follows active-level input", int'(pwm), 0);
    endtask

    task automatic t_basic();
        start_run(64, 1'b1, 0);
        measure(64, 1'b1, 0, "R2", -1, 0, 1'b0, 0);
        start_run(100, 1'b0, 1);
        measure(100, 1'b0, 1, "R2", -1, 0, 1'b0, 0);
    endtask

    task automatic t_continuous();
        start_run(10, 1'b1, 0);
        measure(10, 1'b1, 0, "R1", -1, 0, 1'b0, 0);
        measure(10, 1'b1, 0, "R1", -1, 0, 1'b0, 0);
    endtask

    task automatic t_zero();
        start_run(0, 1'b1, 0);
        measure(0, 1'b1, 0, "R3", -1, 0, 1'b0, 0);
        start_run(0, 1'b0, 1);
        measure(0, 1'b0, 1, "R3", -1, 0, 1'b0, 0);
    endtask

    task automatic t_full();
        start_run(255, 1'b1, 2);
        measure(255, 1'b1, 2, "R4", -1, 0, 1'b0, 0);
        start_run(255, 1'b0, 0);
        measure(255, 1'b0, 0, "R4", -1, 0, 1'b0, 0);
    endtask

    task automatic t_rates();
        for (int s = 0; s < 4; s++) begin
            start_run(37, 1'b1, s);
            measure(37, 1'b1, s, "R5", -1, 0, 1'b0, 0);
        end
    endtask

    task automatic t_midchange();
        start_run(50, 1'b1, 0);
        measure(50, 1'b1, 0, "R6", 100, 200, 1'b0, 1);
        measure(200, 1'b0, 1, "R6", -1, 0, 1'b0, 0);
    endtask

    task automatic t_disable();
        start_run(90, 1'b1, 0);
        repeat (40) @(negedge clk);
        check(pwm == 1'b1, "R2", "pin inside active window", int'(pwm), 1);
        enable = 1'b0;
        @(negedge clk);
        check(pwm == 1'b0, "R7", "pin one clock after disable", int'(pwm), 0);
        pol = 1'b0;
        @(negedge clk);
        check(pwm == 1'b1, "R7", "idle pin after active-level change", int'(pwm), 1);
        repeat (5) @(negedge clk);
        check(pwm == 1'b1, "R7", "idle pin holds", int'(pwm), 1);
        start_run(90, 1'b1, 1);
        measure(90, 1'b1, 1, "R7", -1, 0, 1'b0, 0);
    endtask

    initial begin : watchdog
        #(4ns * 190000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        t_reset();
        t_basic();
        t_continuous();
        t_zero();
        t_full();
        t_rates();
        t_midchange();
        t_disable();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule